// File: doc/BRIEF.md
# DMA Channel Control with Destination Stepping and Acknowledge Output

This block holds the per-channel control fields of a four-channel DMA controller and acts on them in two ways. Each channel has a destination-address register. After every completed transfer on that channel it is held, raised or lowered by a step that depends on the transfer size. Channel 0 also drives the acknowledge pin. Its own control bits choose the cycle phase in which the pin is asserted and the pin's polarity.

Software reaches the block through a small register bus. A write or read names a channel and picks either the control word or the destination address. The transfer engine reports each completed transfer with a strobe, the channel number, the size code and a flag that marks a destination in the X/Y memory region. On each cycle it also gives the owning channel, the address mode (single or dual) and read/write phase strobes. Some settings are not allowed. When a transfer completes under one of them, the block raises a one-cycle illegal-setting flag and leaves the address unchanged.

Top module: `dma_ctl_top`

## Requirements
- R1: After reset, every control word reads 0 and every destination address is 0. The acknowledge pin is high and the illegal flag is low.
- R2: A bus write with `bus_sel`=0 stores the control word: bits [1:0] are the destination mode, bit 2 is the ack-phase select and bit 3 is the ack polarity. With `bus_sel`=1 the write loads the destination address. `bus_rdata` returns the selected word in the same cycle. A bus address write beats a transfer update to the same channel in the same cycle.
- R3: Mode 00 (fixed) leaves the destination address unchanged after a legal transfer.
- R4: Mode 01 adds 1, 2, 4 or 16 for size codes 0, 1, 2 and 3 (8-bit, 16-bit, 32-bit, 16-byte). The result wraps modulo 2^32.
- R5: Mode 10 subtracts 1, 2 or 4 for size codes 0, 1 and 2. The result wraps modulo 2^32.
- R6: Three settings are illegal: mode 11 at any size, mode 10 with size code 3, and mode 00 with size code 3 and `dst_xy`=1. A transfer under any of them pulses `illegal` high for exactly the next cycle and leaves the address unchanged. No other transfer raises `illegal`.
- R7: A transfer strobe changes only the address of the channel named by `xfer_ch`.
- R8: In dual mode, the acknowledge for a channel 0 cycle is active during `rd_phase` when the ack-phase bit is 0 and during `wr_phase` when it is 1. Cycles owned by other channels never activate it.
- R9: In single mode, the acknowledge is active during either phase of a channel 0 cycle, whatever the ack-phase bit holds.
- R10: With polarity bit 0 the pin is active-low and idles high. With polarity bit 1 it is active-high and idles low. The pin is combinational from its inputs.
- R11: On channels 1 to 3, writes to bits 3:2 of the control word are dropped. Those bits read back as 0 and have no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = control word, 1 = destination address |
| bus_ch | input | 2 | Channel selected by the bus |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected channel and word |
| xfer_done | input | 1 | One transfer completed |
| xfer_ch | input | 2 | Channel of the completed transfer |
| xfer_size | input | 2 | Size code 0..3 = 8-bit, 16-bit, 32-bit, 16-byte |
| dst_xy | input | 1 | Destination lies in the X/Y memory region |
| dual_mode | input | 1 | 1 = dual address mode, 0 = single |
| cyc_ch | input | 2 | Channel that owns the current bus cycle |
| rd_phase | input | 1 | Current cycle is in its read phase |
| wr_phase | input | 1 | Current cycle is in its write phase |
| dest_addr | output | 128 | Destination addresses, channel n in bits [32n+31:32n] |
| dack | output | 1 | Acknowledge pin |
| illegal | output | 1 | One-cycle pulse after a transfer under an illegal setting |

## Verification
The bench targets the address wrap at both ends of the range. A design that saturates or truncates the sum would leave 0xFFFFFFFF or lose the carry. It also drives every illegal combination next to a neighbouring legal one: fixed 16-byte without the X/Y flag, and decrement at 32-bit. A decoder that is too broad or too narrow would flag the wrong transfer, or would step an address it should hold. Acknowledge-bit writes to channels 1 to 3 are followed by read-back, and the pin is watched during channel 1 cycles. A design that stores those bits, or fails to qualify the pin by channel, would show either 1s in the read or a toggling pin. A bus write that collides with a transfer update on the same channel shows whether the bus write takes priority.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  typedef enum logic [1:0] {
    DM_FIXED = 2'b00,
    DM_INC   = 2'b01,
    DM_DEC   = 2'b10,
    DM_RSVD  = 2'b11
  } dst_mode_e;

  typedef enum logic [1:0] {
    SZ_B8   = 2'b00,
    SZ_B16  = 2'b01,
    SZ_B32  = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  // control word: {ack_level, ack_phase, dmode}
  typedef struct packed {
    logic      ack_level;
    logic      ack_phase;
    dst_mode_e dmode;
  } chan_ctl_t;

  localparam int CTL_W = $bits(chan_ctl_t);

  // byte count moved by one transfer of the given size
  function automatic logic [4:0] step_bytes(xfer_size_e s);
    case (s)
      SZ_B8:   step_bytes = 5'd1;
      SZ_B16:  step_bytes = 5'd2;
      SZ_B32:  step_bytes = 5'd4;
      default: step_bytes = 5'd16;
    endcase
  endfunction

  // forbidden combinations of mode, size and X/Y destination
  function automatic logic setting_bad(dst_mode_e m, xfer_size_e s, logic xy);
    setting_bad = (m == DM_RSVD)
               || (m == DM_DEC   && s == SZ_LINE)
               || (m == DM_FIXED && s == SZ_LINE && xy);
  endfunction

endpackage

// File: rtl/dma_step_calc.sv
module dma_step_calc
  import dma_ctl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_addr,
  input  dst_mode_e     mode,
  input  xfer_size_e    size,
  input  logic          xy,
  output logic [AW-1:0] next_addr,
  output logic          bad
);

  logic [AW-1:0] mag;

  always_comb begin
    mag = AW'(step_bytes(size));
    bad = setting_bad(mode, size, xy);
    case (mode)
      DM_INC:  next_addr = cur_addr + mag;
      DM_DEC:  next_addr = cur_addr - mag;
      default: next_addr = cur_addr;
    endcase
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_ctl_pkg::*;
#(
  parameter int AW      = 32,
  parameter bit HAS_ACK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic          wr_addr,
  input  chan_ctl_t     ctl_wdata,
  input  logic [AW-1:0] addr_wdata,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_addr,
  output chan_ctl_t     ctl_q,
  output logic [AW-1:0] addr_q
);

  chan_ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_wdata;
    if (!HAS_ACK) begin
      ctl_d.ack_level = 1'b0;
      ctl_d.ack_phase = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      addr_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_d;
      if (wr_addr)     addr_q <= addr_wdata;
      else if (upd_en) addr_q <= upd_addr;
    end
  end

  // R7: with no write and no update for this channel, the address holds
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_addr && !upd_en) |=> $stable(addr_q));

  // R4 and R5: a stepping mode always moves the address on a legal update
  assert_step_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_addr && (ctl_q.dmode == DM_INC || ctl_q.dmode == DM_DEC))
      |=> (addr_q != $past(addr_q)));

endmodule

// File: rtl/dma_dack_gen.sv
module dma_dack_gen #(
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ack_phase,
  input  logic           ack_level,
  input  logic           dual_mode,
  input  logic [CHW-1:0] cyc_ch,
  input  logic           rd_phase,
  input  logic           wr_phase,
  output logic           dack
);

  logic own_cycle;
  logic phase_hit;
  logic ack_active;

  always_comb begin
    own_cycle  = (cyc_ch == '0);
    phase_hit  = dual_mode ? (ack_phase ? wr_phase : rd_phase)
                           : (rd_phase | wr_phase);
    ack_active = own_cycle && phase_hit;
    dack       = ack_level ? ack_active : ~ack_active;
  end

  // R10: with no phase strobe, the pin sits at its inactive level
  assert_dack_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_phase && !wr_phase) |-> (dack == ~ack_level));

  // R8: cycles owned by other channels never activate the pin
  assert_dack_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ch != '0) |-> (dack == ~ack_level));

endmodule

// File: rtl/dma_ctl_top.sv
module dma_ctl_top
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_sel,
  input  logic [CHW-1:0]    bus_ch,
  input  logic [AW-1:0]     bus_wdata,
  output logic [AW-1:0]     bus_rdata,
  input  logic              xfer_done,
  input  logic [CHW-1:0]    xfer_ch,
  input  logic [1:0]        xfer_size,
  input  logic              dst_xy,
  input  logic              dual_mode,
  input  logic [CHW-1:0]    cyc_ch,
  input  logic              rd_phase,
  input  logic              wr_phase,
  output logic [NCH*AW-1:0] dest_addr,
  output logic              dack,
  output logic              illegal
);

  chan_ctl_t     ctl_q  [NCH];
  logic [AW-1:0] addr_q [NCH];
  logic [NCH-1:0] wr_ctl_hit;
  logic [NCH-1:0] wr_addr_hit;
  logic [NCH-1:0] upd_hit;

  logic [AW-1:0] sel_addr;
  dst_mode_e     sel_mode;
  logic [AW-1:0] step_next;
  logic          step_bad;
  logic          illegal_q;
  chan_ctl_t     ctl_wdata;

  assign ctl_wdata = chan_ctl_t'(bus_wdata[CTL_W-1:0]);
  assign sel_addr  = addr_q[xfer_ch];
  assign sel_mode  = ctl_q[xfer_ch].dmode;

  // one shared step unit serves whichever channel completed
  dma_step_calc #(.AW(AW)) u_step (
    .cur_addr  (sel_addr),
    .mode      (sel_mode),
    .size      (xfer_size_e'(xfer_size)),
    .xy        (dst_xy),
    .next_addr (step_next),
    .bad       (step_bad)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_ctl_hit[i]  = bus_we && !bus_sel && (bus_ch == CHW'(i));
    assign wr_addr_hit[i] = bus_we &&  bus_sel && (bus_ch == CHW'(i));
    assign upd_hit[i]     = xfer_done && !step_bad && (xfer_ch == CHW'(i));

    dma_chan_regs #(.AW(AW), .HAS_ACK(i == 0)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctl     (wr_ctl_hit[i]),
      .wr_addr    (wr_addr_hit[i]),
      .ctl_wdata  (ctl_wdata),
      .addr_wdata (bus_wdata),
      .upd_en     (upd_hit[i]),
      .upd_addr   (step_next),
      .ctl_q      (ctl_q[i]),
      .addr_q     (addr_q[i])
    );

    assign dest_addr[i*AW +: AW] = addr_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= xfer_done && step_bad;
  end
  assign illegal = illegal_q;

  always_comb begin
    if (bus_sel) bus_rdata = addr_q[bus_ch];
    else         bus_rdata = {{(AW-CTL_W){1'b0}}, ctl_q[bus_ch]};
  end

  dma_dack_gen #(.CHW(CHW)) u_dack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_phase (ctl_q[0].ack_phase),
    .ack_level (ctl_q[0].ack_level),
    .dual_mode (dual_mode),
    .cyc_ch    (cyc_ch),
    .rd_phase  (rd_phase),
    .wr_phase  (wr_phase),
    .dack      (dack)
  );

  // R6: an illegal transfer raises the flag on the next cycle
  assert_bad_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && step_bad) |=> illegal);

  // R6: the flag never rises without a transfer strobe before it
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(xfer_done));

  // R11: ack bits of channels other than 0 read as zero
  assert_ro_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && bus_ch != '0) |-> (bus_rdata[CTL_W-1:CTL_W-2] == 2'b00));

endmodule

// File: tb/sim_dma_ctl_top.sv
`timescale 1ns/1ps
module sim_dma_ctl_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0, bus_sel = 1'b0;
  logic [1:0]   bus_ch = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         xfer_done = 1'b0;
  logic [1:0]   xfer_ch = '0, xfer_size = '0;
  logic         dst_xy = 1'b0, dual_mode = 1'b0;
  logic [1:0]   cyc_ch = '0;
  logic         rd_phase = 1'b0, wr_phase = 1'b0;
  logic [127:0] dest_addr;
  logic         dack, illegal;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dma_ctl_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_ch(bus_ch), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .xfer_ch(xfer_ch), .xfer_size(xfer_size),
    .dst_xy(dst_xy), .dual_mode(dual_mode), .cyc_ch(cyc_ch),
    .rd_phase(rd_phase), .wr_phase(wr_phase), .dest_addr(dest_addr),
    .dack(dack), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input int ch);
    return dest_addr[ch*32 +: 32];
  endfunction

  // bench's own view of the step: 1 << size, except 16 for code 3
  function automatic logic [31:0] model_step(input logic [1:0] mode, input logic [1:0] sz,
                                             input logic [31:0] a);
    logic [31:0] n;
    n = (sz == 2'd3) ? 32'd16 : (32'd1 << sz);
    if (mode == 2'b01) return a + n;
    if (mode == 2'b10) return a - n;
    return a;
  endfunction

  task automatic wr(input logic [1:0] ch, input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = sel; bus_ch = ch; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ch, input logic sel, output logic [31:0] d);
    bus_sel = sel; bus_ch = ch;
    #1 d = bus_rdata;
  endtask

  // one transfer strobe; on return the update and the flag are visible
  task automatic xfer(input logic [1:0] ch, input logic [1:0] sz, input logic xy);
    @(negedge clk);
    xfer_done = 1'b1; xfer_ch = ch; xfer_size = sz; dst_xy = xy;
    @(negedge clk);
    xfer_done = 1'b0; dst_xy = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      rd(c[1:0], 1'b0, d); chk("R1 ctl", d, 0);
      chk("R1 addr", addr_of(c), 0);
    end
    chk("R1 dack", {31'b0, dack}, 1);
    chk("R1 illegal", {31'b0, illegal}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd0, 1'b0, 32'h0000_000E);
    rd(2'd0, 1'b0, d); chk("R2 ctl0", d, 32'hE);
    wr(2'd3, 1'b1, 32'hDEAD_BEEF);
    rd(2'd3, 1'b1, d); chk("R2 addr3", d, 32'hDEAD_BEEF);
    chk("R2 dest3 port", addr_of(3), 32'hDEAD_BEEF);
    wr(2'd0, 1'b0, 32'h0);
  endtask

  task automatic t_fixed;
    wr(2'd0, 1'b1, 32'h0000_1000);
    xfer(2'd0, 2'd2, 1'b0);
    chk("R3 fixed 32b", addr_of(0), 32'h1000);
    chk("R3 no flag", {31'b0, illegal}, 0);
    xfer(2'd0, 2'd3, 1'b0);
    chk("R3 fixed 16B non-XY", addr_of(0), 32'h1000);
    chk("R3 fixed 16B no flag", {31'b0, illegal}, 0);
  endtask

  task automatic t_inc;
    logic [31:0] e;
    wr(2'd1, 1'b0, 32'h1);
    wr(2'd1, 1'b1, 32'h100);
    e = 32'h100;
    for (int s = 0; s < 4; s++) begin
      e = model_step(2'b01, s[1:0], e);
      xfer(2'd1, s[1:0], 1'b0);
      chk("R4 inc", addr_of(1), e);
    end
    wr(2'd1, 1'b1, 32'hFFFF_FFFE);
    xfer(2'd1, 2'd2, 1'b0);
    chk("R4 wrap up", addr_of(1), 32'h0000_0002);
  endtask

  task automatic t_dec;
    logic [31:0] e;
    wr(2'd2, 1'b0, 32'h2);
    wr(2'd2, 1'b1, 32'h40);
    e = 32'h40;
    for (int s = 0; s < 3; s++) begin
      e = model_step(2'b10, s[1:0], e);
      xfer(2'd2, s[1:0], 1'b0);
      chk("R5 dec", addr_of(2), e);
    end
    wr(2'd2, 1'b1, 32'h0);
    xfer(2'd2, 2'd0, 1'b0);
    chk("R5 wrap down", addr_of(2), 32'hFFFF_FFFF);
  endtask

  task automatic t_illegal;
    wr(2'd2, 1'b1, 32'h80);
    xfer(2'd2, 2'd3, 1'b0);
    chk("R6 dec 16B flag", {31'b0, illegal}, 1);
    chk("R6 dec 16B addr held", addr_of(2), 32'h80);
    @(negedge clk);
    chk("R6 flag one cycle", {31'b0, illegal}, 0);
    wr(2'd3, 1'b0, 32'h3);
    xfer(2'd3, 2'd0, 1'b0);
    chk("R6 reserved flag", {31'b0, illegal}, 1);
    chk("R6 reserved addr held", addr_of(3), 32'hDEAD_BEEF);
    xfer(2'd0, 2'd3, 1'b1);
    chk("R6 fixed 16B XY flag", {31'b0, illegal}, 1);
    chk("R6 fixed 16B XY addr", addr_of(0), 32'h1000);
    xfer(2'd2, 2'd2, 1'b0);
    chk("R6 legal dec no flag", {31'b0, illegal}, 0);
    chk("R6 legal dec moved", addr_of(2), 32'h7C);
  endtask

  task automatic t_select;
    logic [31:0] a0, a2, a3;
    a0 = addr_of(0); a2 = addr_of(2); a3 = addr_of(3);
    xfer(2'd1, 2'd0, 1'b0);
    chk("R7 ch1 moved", addr_of(1), 32'h3);
    chk("R7 ch0 kept", addr_of(0), a0);
    chk("R7 ch2 kept", addr_of(2), a2);
    chk("R7 ch3 kept", addr_of(3), a3);
  endtask

  task automatic t_clash;
    @(negedge clk);
    bus_we = 1'b1; bus_sel = 1'b1; bus_ch = 2'd1; bus_wdata = 32'h5555_0000;
    xfer_done = 1'b1; xfer_ch = 2'd1; xfer_size = 2'd2;
    @(negedge clk);
    bus_we = 1'b0; xfer_done = 1'b0;
    chk("R2 write beats update", addr_of(1), 32'h5555_0000);
  endtask

  task automatic phase(input logic [1:0] ch, input logic dm, input logic r, input logic w,
                       input logic exp, input string req);
    cyc_ch = ch; dual_mode = dm; rd_phase = r; wr_phase = w;
    #1 chk(req, {31'b0, dack}, {31'b0, exp});
    rd_phase = 1'b0; wr_phase = 1'b0;
  endtask

  task automatic t_dack;
    logic [31:0] d;
    wr(2'd0, 1'b0, 32'h0);
    phase(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 dual AM0 read active-low");
    phase(2'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 dual AM0 write idle");
    phase(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, "R8 other channel idle");
    wr(2'd0, 1'b0, 32'h4);
    phase(2'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R8 dual AM1 write active");
    phase(2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R8 dual AM1 read idle");
    phase(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 single read active");
    phase(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 single write active");
    wr(2'd0, 1'b0, 32'h8);
    phase(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 AL1 idle low");
    phase(2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R10 AL1 active-high");
    wr(2'd0, 1'b0, 32'h0);
    phase(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 AL0 idle high");
    // R11: ack bits on channels 1..3 are dropped
    for (int c = 1; c < 4; c++) begin
      wr(c[1:0], 1'b0, 32'hD);
      rd(c[1:0], 1'b0, d); chk("R11 ack bits read 0", d, 32'h1);
    end
    phase(2'd1, 1'b1, 1'b0, 1'b1, 1'b1, "R11 no effect on pin");
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_fixed();
    t_inc();
    t_dec();
    t_illegal();
    t_select();
    t_clash();
    t_dack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule